// File: doc/BRIEF.md
# Filtered Reset Conditioner with Minimum Stretch

This block turns a noisy, asynchronous, active-low reset pin into a clean internal reset for a processor core. The pin is first brought into the clock domain through a short flop chain. A run-length filter then watches the synchronized level and treats a low level as a genuine reset request only once it has been seen on more than a fixed number of consecutive clock edges. Shorter dips are thrown away.

When a request qualifies, the internal reset is raised and a stretch counter guarantees a minimum assertion time. If the pin is still low when that time runs out, the internal reset follows the pin and drops only after the pin has returned high. The block also drives the fixed program address at which the core starts fetching once reset releases. At power-up the internal reset is already high and is held for the minimum stretch time, so the core never runs before the first full evaluation.

Top module: `rst_conditioner`

## Requirements
- R1: A low level on `ext_rst_n_i` that lasts for FILT_LEN (default 4) or fewer consecutive rising clock edges never raises `core_rst_o`.
- R2: When `ext_rst_n_i` is sampled low on FILT_LEN+1 or more consecutive edges, `core_rst_o` rises right after the edge numbered FILT_LEN+3 (default 7), counted from the first edge that samples the pin low: two edges of synchronization, then the fifth filter edge.
- R3: Once raised by a request, `core_rst_o` stays high for at least MIN_HOLD (default 18) cycles. A request whose low run lasts between FILT_LEN+1 and MIN_HOLD+FILT_LEN edges gives exactly MIN_HOLD high cycles.
- R4: If the pin stays low past the minimum time, `core_rst_o` stays high and falls right after the third edge that samples the pin high again. A run of L low samples then gives L-4 high cycles.
- R5: From power-up with the pin high, `core_rst_o` is high before the first clock edge and stays high for exactly MIN_HOLD cycles, falling right after edge MIN_HOLD.
- R6: `pc_start_o` is always the start address 0x000C on a 16-bit bus.
- R7: A fresh qualifying request that arrives while the stretch count is running restarts the count from its own latch edge. A dip of FILT_LEN or fewer edges during the count does not extend it.
- R8: The filter's run count clears as soon as one high sample is seen. Two dips of 3 edges each, separated by a single high edge, do not combine into a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| ext_rst_n_i | input | 1 | Asynchronous active-low external reset pin |
| core_rst_o | output | 1 | Registered active-high internal reset for the core |
| pc_start_o | output | VEC_W | Registered program start address used when reset releases |

## Verification
The bench targets the filter threshold from both sides. A 4-edge dip must leave the reset low, and a 5-edge dip must raise it on exactly the seventh edge. A design with an off-by-one threshold or a missing synchronizer stage shows up as a missed reset or a wrong latch edge. Pulse lengths on both sides of the point where the pin duration overtakes the minimum count check that the reset lasts for the longer of the two, not their sum, and that release waits for the synchronized high level. Back-to-back dips separated by one high sample catch a filter counter that fails to clear. Short and qualifying dips during a running stretch separate a correct restart from one that reloads on noise or never reloads.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_FILT_LEN    = 4;
  localparam int unsigned DEF_MIN_HOLD    = 18;
  localparam int unsigned DEF_VEC_W       = 16;
  localparam logic [DEF_VEC_W-1:0] DEF_RESET_VEC = 16'h000C;

  // Width needed to hold any value from 0 up to and including n.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);

  // All stages power up in the released (high) state.
  logic [STAGES-1:0] chain_q = '1;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) chain_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i) chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstc_filter.sv
module rstc_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic sync_n_i,
  output logic trig_o,
  output logic held_o
);

  import rstc_pkg::*;

  // Run counter saturates one past the threshold, so the trigger
  // fires once per low episode and "held" marks the rest of it.
  localparam int unsigned SAT = FILT_LEN + 1;
  localparam int unsigned CW  = cnt_w(SAT);
  localparam logic [CW-1:0] THR  = CW'(FILT_LEN);
  localparam logic [CW-1:0] TOP  = CW'(SAT);

  logic [CW-1:0] run_q = '0;

  always_ff @(posedge clk_i) begin
    if (sync_n_i) begin
      run_q <= '0;
    end else if (run_q != TOP) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign trig_o = !sync_n_i && (run_q == THR);
  assign held_o = !sync_n_i && (run_q == TOP);

endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int unsigned MIN_HOLD = 18
) (
  input  logic clk_i,
  input  logic trig_i,
  input  logic held_i,
  output logic rst_o
);

  import rstc_pkg::*;

  localparam int unsigned HW = cnt_w(MIN_HOLD);
  localparam logic [HW-1:0] LOAD = HW'(MIN_HOLD - 1);

  // Power-up: reset already asserted with a full stretch pending.
  logic [HW-1:0] hold_q = LOAD;
  logic          rst_q  = 1'b1;

  always_ff @(posedge clk_i) begin
    rst_q <= trig_i || held_i || (hold_q != '0);
    if (trig_i) begin
      hold_q <= LOAD;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign rst_o = rst_q;

endmodule

// File: rtl/rst_conditioner.sv
module rst_conditioner #(
  parameter int unsigned SYNC_STAGES = rstc_pkg::DEF_SYNC_STAGES,
  parameter int unsigned FILT_LEN    = rstc_pkg::DEF_FILT_LEN,
  parameter int unsigned MIN_HOLD    = rstc_pkg::DEF_MIN_HOLD,
  parameter int unsigned VEC_W       = rstc_pkg::DEF_VEC_W,
  parameter logic [VEC_W-1:0] RESET_VEC = VEC_W'(rstc_pkg::DEF_RESET_VEC)
) (
  input  logic             clk_i,
  input  logic             ext_rst_n_i,
  output logic             core_rst_o,
  output logic [VEC_W-1:0] pc_start_o
);

  logic sync_n;
  logic trig;
  logic held;

  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (ext_rst_n_i),
    .q_o   (sync_n)
  );

  rstc_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i    (clk_i),
    .sync_n_i (sync_n),
    .trig_o   (trig),
    .held_o   (held)
  );

  rstc_stretch #(.MIN_HOLD(MIN_HOLD)) u_str (
    .clk_i  (clk_i),
    .trig_i (trig),
    .held_i (held),
    .rst_o  (core_rst_o)
  );

  logic [VEC_W-1:0] vec_q = RESET_VEC;

  always_ff @(posedge clk_i) vec_q <= RESET_VEC;

  assign pc_start_o = vec_q;

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
  parameter int unsigned FILT_LEN = 4,
  parameter int unsigned MIN_HOLD = 18,
  parameter int unsigned VEC_W    = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = 16'h000C
) (
  input logic             clk_i,
  input logic             ext_rst_n_i,
  input logic             core_rst_o,
  input logic [VEC_W-1:0] pc_start_o
);

  logic [1:0] arm_q   = '0;
  int unsigned lo_run = 0;
  int unsigned hi_run = 0;

  always_ff @(posedge clk_i) begin
    if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
    lo_run <= ext_rst_n_i ? 0 : ((lo_run < FILT_LEN + 8) ? lo_run + 1 : lo_run);
    hi_run <= core_rst_o ? ((hi_run < MIN_HOLD + 8) ? hi_run + 1 : hi_run) : 0;
  end

  // R1 / R2: a rise needs a long enough low run on the pin.
  p_no_short_trigger_r1: assert property (@(posedge clk_i) disable iff (arm_q != 2'd3)
    $rose(core_rst_o) |-> ($past(lo_run, 2) > FILT_LEN));

  // R3: every high interval lasts at least the minimum.
  p_min_hold_r3: assert property (@(posedge clk_i) disable iff (arm_q != 2'd3)
    $fell(core_rst_o) |-> (hi_run >= MIN_HOLD));

  // R4: a long low level keeps the core in reset.
  p_follow_pin_r4: assert property (@(posedge clk_i) disable iff (arm_q != 2'd3)
    (lo_run >= FILT_LEN + 3) |-> core_rst_o);

  // R6: start vector never changes.
  p_vector_r6: assert property (@(posedge clk_i) disable iff (arm_q != 2'd3)
    pc_start_o == RESET_VEC);

endmodule

bind rst_conditioner rstc_checker #(
  .FILT_LEN (FILT_LEN),
  .MIN_HOLD (MIN_HOLD),
  .VEC_W    (VEC_W),
  .RESET_VEC(RESET_VEC)
) u_chk (
  .clk_i       (clk_i),
  .ext_rst_n_i (ext_rst_n_i),
  .core_rst_o  (core_rst_o),
  .pc_start_o  (pc_start_o)
);

// File: tb/sim_rst_conditioner.sv
module sim_rst_conditioner;

  localparam int PERIOD = 10;
  localparam int FL = 4;
  localparam int MH = 18;
  localparam int W  = 80;

  logic        clk = 1'b0;
  logic        ext_n = 1'b1;
  logic        core_rst;
  logic [15:0] pc_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rst_conditioner u0 (
    .clk_i       (clk),
    .ext_rst_n_i (ext_n),
    .core_rst_o  (core_rst),
    .pc_start_o  (pc_start)
  );

  always #(PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference: a two-deep delay queue for the pin, the
  // length of the current low run, and the remaining stretch.
  bit q_dly[$] = '{1'b1, 1'b1};
  int m_run  = 0;
  int m_left = MH - 1;
  bit m_rst  = 1'b1;

  always @(posedge clk) begin
    bit seen;
    bit fresh;
    seen = q_dly[0];
    void'(q_dly.pop_front());
    q_dly.push_back(ext_n);
    fresh = !seen && (m_run == FL);
    m_rst = fresh || (!seen && m_run > FL) || (m_left > 0);
    if (fresh) m_left = MH - 1;
    else if (m_left > 0) m_left--;
    m_run = seen ? 0 : m_run + 1;
  end

  always @(negedge clk) begin
    if (!done) begin
      check(core_rst === m_rst, "R2/R3/R4 model", int'(core_rst), int'(m_rst));
      check(pc_start === 16'h000C, "R6 vector", int'(pc_start), 12);
    end
  end

  task automatic idle(input int n);
    ext_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // Sample j is low for j in [1,l1] and [l1+g+1, l1+g+l2].
  task automatic run_seq(input int l1, input int g, input int l2,
                         output int first, output int cnt);
    first = 0;
    cnt   = 0;
    ext_n = (l1 > 0) ? 1'b0 : 1'b1;
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      if (core_rst) begin
        cnt++;
        if (first == 0) first = i;
      end
      ext_n = !(((i + 1) <= l1) ||
                ((i + 1) > l1 + g && (i + 1) <= l1 + g + l2));
    end
    ext_n = 1'b1;
  endtask

  task automatic single(input int len);
    int f;
    int c;
    int exp_c;
    run_seq(len, 0, 0, f, c);
    if (len <= FL) begin
      check(c == 0, "R1 short dip ignored", c, 0);
    end else begin
      exp_c = (len - 4 > MH) ? len - 4 : MH;
      check(f == FL + 3, "R2 latch edge", f, FL + 3);
      if (len - 4 > MH) check(c == exp_c, "R4 follows long pin low", c, exp_c);
      else              check(c == exp_c, "R3 minimum stretch", c, exp_c);
    end
    idle(30);
  endtask

  initial begin
    int f;
    int c;
    #1;
    check(core_rst === 1'b1, "R5 reset state at power-up", int'(core_rst), 1);
    check(pc_start === 16'h000C, "R6 vector at power-up", int'(pc_start), 12);
    for (int k = 1; k <= MH; k++) begin
      @(negedge clk);
      if (k == MH - 1) check(core_rst === 1'b1, "R5 held through power-up", int'(core_rst), 1);
      if (k == MH)     check(core_rst === 1'b0, "R5 power-up release", int'(core_rst), 0);
    end
    idle(10);

    single(1);
    single(3);
    single(4);   // R1 boundary
    single(5);   // R2 boundary
    single(12);
    single(22);  // R3/R4 crossover
    single(23);
    single(40);

    // R7: qualifying request during the stretch restarts it.
    run_seq(5, 4, 5, f, c);
    check(f == FL + 3, "R7 first latch", f, FL + 3);
    check(c == (5 + 4 + 1) + MH - 1, "R7 restart extends stretch", c, (5 + 4 + 1) + MH - 1);
    idle(30);

    // R7: a short dip during the stretch does not extend it.
    run_seq(5, 4, 3, f, c);
    check(c == MH, "R7 short dip in stretch ignored", c, MH);
    idle(30);

    // R8: two 3-edge dips split by one high sample stay ignored.
    run_seq(3, 1, 3, f, c);
    check(c == 0, "R8 run counter clears", c, 0);
    idle(10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule